// File: doc/BRIEF.md
# Burst-Policy Clock Source Selector

This block keeps a single 32-bit policy word that pairs a processor activity state with a clock-source code for each state. The top nibble of the word carries the state flags. Each activity state has its own 4-bit source field in the low bits. The block priority-decodes the flag nibble to find the active state. It then takes the source code stored for that state and presents it as a registered mux select, together with a flag that says whether the code points at a populated source slot.

Software programs the word through a plain write port and reads it back on the same cycle-aligned read port. The read returns the stored word, so software can write and then read to confirm the update. The clock sources, glitch-free switching and dividers are outside the block. Only the select value is produced. A parameter mask lists the populated codes, and a select-width parameter covers a smaller eight-source variant.

Top module: `clk_policy_sel`

## Requirements
- R1: After reset, the read port returns 0x1000_0000 (state IDLE, every source field 0), `state_o` is 1, `sel_o` is 0 and `sel_valid_o` is 1.
- R2: The clock edge that captures a write makes the read port return the written word, with the reserved bits cleared.
- R3: Bits 27:20 of the stored word always read as zero, whatever was written there.
- R4: The state nibble in bits 31:28 is decoded with highest-priority-first ordering. Bit 31 gives FIQ (4), bit 30 gives IRQ (3), bit 29 gives RUN (2) and bit 28 gives IDLE (1). When several bits are set, the highest set bit wins.
- R5: For decoded state s, `sel_o` equals bits [4s+3:4s] of the stored word: STANDBY 3:0, IDLE 7:4, RUN 11:8, IRQ 15:12 and FIQ 19:16.
- R6: `sel_o`, `sel_valid_o` and `state_o` follow a write on the same edge that stores it. They stay unchanged in any cycle without a write.
- R7: With the default mask, codes 1, 3, 6, 7, 10, 11, 12 and 13 drive `sel_valid_o` low and every other code drives it high.
- R8: An all-zero state nibble decodes to STANDBY (0), and the select then comes from bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the policy word |
| wr_data_i | input | 32 | Policy word to store |
| rd_data_o | output | 32 | Stored policy word |
| sel_o | output | 4 | Registered source select |
| sel_valid_o | output | 1 | Registered flag: selected code is a populated slot |
| state_o | output | 3 | Decoded activity state |

## Verification
The hardest case is a word in which several state bits are set and every source field holds a different code. Only then does a wrong priority or a wrong field offset show up as a different select. The stimulus sweeps all sixteen state nibbles over words whose five fields are all distinct. It then walks every code through every field, so that each hole is hit in each state. Random words, including ones with the reserved bits set, are mixed with idle cycles so that the hold behaviour is checked between writes.

// File: rtl/clk_policy_pkg.sv
package clk_policy_pkg;
  localparam int FIELD_W    = 4;
  localparam int NUM_STATES = 5;

  typedef enum logic [2:0] {
    ST_STANDBY = 3'd0,
    ST_IDLE    = 3'd1,
    ST_RUN     = 3'd2,
    ST_IRQ     = 3'd3,
    ST_FIQ     = 3'd4
  } act_state_e;
endpackage

// File: rtl/policy_reg.sv
module policy_reg #(
  parameter int                 DATA_W  = 32,
  parameter logic [DATA_W-1:0]  WR_MASK = '1,
  parameter logic [DATA_W-1:0]  RST_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o,
  output logic [DATA_W-1:0] next_o
);
  logic [DATA_W-1:0] q;

  assign next_o = we_i ? (d_i & WR_MASK) : q;
  assign q_o    = q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= RST_VAL;
    else if (we_i) q <= d_i & WR_MASK;
  end

  a_r3_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q & ~WR_MASK) == '0);
endmodule

// File: rtl/state_decode.sv
module state_decode
  import clk_policy_pkg::*;
(
  input  logic [3:0] nib_i,
  output act_state_e st_o
);
  always_comb begin
    if      (nib_i[3]) st_o = ST_FIQ;
    else if (nib_i[2]) st_o = ST_IRQ;
    else if (nib_i[1]) st_o = ST_RUN;
    else if (nib_i[0]) st_o = ST_IDLE;
    else               st_o = ST_STANDBY;
  end
endmodule

// File: rtl/src_pick.sv
module src_pick
  import clk_policy_pkg::*;
#(
  parameter int                      SEL_W     = 4,
  parameter logic [2**FIELD_W-1:0]   POPULATED = '1,
  localparam int                     FIELDS_W  = NUM_STATES*FIELD_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [FIELDS_W-1:0] fields_i,
  input  act_state_e          st_i,
  output logic [FIELD_W-1:0]  sel_o,
  output logic                valid_o
);
  localparam int NCODES = 1 << SEL_W;

  logic [FIELD_W-1:0] field [NUM_STATES];
  logic [FIELD_W-1:0] code;
  logic               code_ok;

  for (genvar s = 0; s < NUM_STATES; s++) begin : g_field
    assign field[s] = fields_i[s*FIELD_W +: FIELD_W];
  end

  always_comb begin
    code = field[0];
    for (int s = 1; s < NUM_STATES; s++)
      if (int'(st_i) == s) code = field[s];
  end

  assign code_ok = (int'(code) < NCODES) && POPULATED[code];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o   <= '0;
      valid_o <= POPULATED[0];
    end else begin
      sel_o   <= code;
      valid_o <= code_ok;
    end
  end

  a_r7_hole_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> POPULATED[sel_o]);
  a_r7_pop_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && int'(sel_o) < NCODES) |-> !POPULATED[sel_o]);
endmodule

// File: rtl/clk_policy_sel.sv
module clk_policy_sel
  import clk_policy_pkg::*;
#(
  parameter int                     DATA_W    = 32,
  parameter int                     STATE_LSB = 28,
  parameter int                     SEL_W     = 4,
  parameter logic [2**FIELD_W-1:0]  POPULATED = 16'hC335
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [FIELD_W-1:0] sel_o,
  output logic              sel_valid_o,
  output logic [2:0]        state_o
);
  localparam int FIELDS_W = NUM_STATES*FIELD_W;
  localparam logic [DATA_W-1:0] ST_MASK  = {{(DATA_W-4){1'b0}}, 4'hF} << STATE_LSB;
  localparam logic [DATA_W-1:0] FLD_MASK = (DATA_W'(1) << FIELDS_W) - DATA_W'(1);
  localparam logic [DATA_W-1:0] WR_MASK  = ST_MASK | FLD_MASK;
  localparam logic [DATA_W-1:0] RST_VAL  = DATA_W'(1) << STATE_LSB;

  logic [DATA_W-1:0] word_q, word_next;
  act_state_e        st_q, st_next;

  policy_reg #(.DATA_W(DATA_W), .WR_MASK(WR_MASK), .RST_VAL(RST_VAL)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en_i),
    .d_i    (wr_data_i),
    .q_o    (word_q),
    .next_o (word_next)
  );

  state_decode u_dec_q (
    .nib_i (word_q[STATE_LSB +: 4]),
    .st_o  (st_q)
  );

  state_decode u_dec_next (
    .nib_i (word_next[STATE_LSB +: 4]),
    .st_o  (st_next)
  );

  src_pick #(.SEL_W(SEL_W), .POPULATED(POPULATED)) u_pick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fields_i (word_next[FIELDS_W-1:0]),
    .st_i     (st_next),
    .sel_o    (sel_o),
    .valid_o  (sel_valid_o)
  );

  assign rd_data_o = word_q;
  assign state_o   = st_q;

  a_r5_field_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o == rd_data_o[int'(state_o)*FIELD_W +: FIELD_W]);
  a_r4_fiq_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[STATE_LSB+3] |-> state_o == ST_FIQ);
  a_r8_standby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[STATE_LSB +: 4] == 4'h0) |-> state_o == ST_STANDBY);
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(sel_o) && $stable(sel_valid_o) && $stable(state_o)));
  a_r2_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o == ($past(wr_data_i) & WR_MASK));
endmodule

// File: tb/clk_policy_sel_test.sv
`timescale 1ns/1ps
module clk_policy_sel_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        we = 0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic [3:0]  sel;
  logic        vld;
  logic [2:0]  st;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  logic [31:0] model_word;

  always #2 clk = ~clk;

  clk_policy_sel uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_data_i(wd),
    .rd_data_o(rd), .sel_o(sel), .sel_valid_o(vld), .state_o(st)
  );

  function automatic int ref_state(logic [31:0] w);
    if (w[31]) return 4;
    if (w[30]) return 3;
    if (w[29]) return 2;
    if (w[28]) return 1;
    return 0;
  endfunction

  function automatic bit ref_valid(int code);
    int holes[$] = '{1, 3, 6, 7, 10, 11, 12, 13};
    foreach (holes[i]) if (holes[i] == code) return 0;
    return 1;
  endfunction

  task automatic check(string req, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    int s = ref_state(model_word);
    int c = (model_word >> (4*s)) & 15;
    check("R2/R3 readback", rd, model_word);
    check(s == 0 ? "R8 standby decode" : "R4 priority decode", st, s);
    check("R5/R6 select", sel, c);
    check("R7 valid", vld, ref_valid(c));
  endtask

  task automatic step(bit w, logic [31:0] d);
    we = w; wd = d;
    @(posedge clk);
    if (w) model_word = d & 32'hF00F_FFFF;
    @(negedge clk);
    we = 0;
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    model_word = 32'h1000_0000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset word", rd, 32'h1000_0000);
    check("R1 reset state", st, 1);
    check("R1 reset sel", sel, 0);
    check("R1 reset valid", vld, 1);

    // R4/R8 every nibble, distinct codes per field
    for (int n = 0; n < 16; n++) step(1, {n[3:0], 8'hFF, 20'h9_5_8_2_4});
    // R3 reserved bits written high
    step(1, 32'h2FF0_0A00);
    check("R3 reserved zero", rd[27:20], 0);
    // R5/R7 every code in every field
    for (int s = 0; s < 5; s++)
      for (int c = 0; c < 16; c++) begin
        logic [31:0] w;
        w = (s == 0) ? 32'h0 : (32'h1 << (27 + s));
        w = w | (32'(c) << (4*s)) | (32'(15 - c) << (4*((s+1)%5)));
        step(1, w);
      end
    // R6 hold across idle cycles with wr_data changing
    step(1, 32'h4000_A000);
    for (int i = 0; i < 6; i++) step(0, $urandom);
    // random mix
    for (int i = 0; i < 400; i++) step(($urandom % 3) != 0, $urandom);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule